// File: doc/BRIEF.md
# I2C Target Controller with Status Flags

This block answers as a target on a two-wire serial bus. It has a 7-bit own address. It recognises its address, or optionally the all-zero broadcast address, and reports the transfer direction as its own status bit. It then moves one byte at a time between the bus and a shared data register. The block stretches the clock (holds SCL low) after the address byte and after every byte. This gives software time to service the data register and clear the matching flag. Software can refuse any received byte by setting a one-shot NACK bit before it releases the stretch. Status flags are cleared by writing 0 to them. Writing 1 to a flag leaves it unchanged. The interrupt line is the OR of the status flags masked by an enable register of the same layout.

Register map, selected by `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | control | bit0 one-shot NACK, bit1 broadcast enable, bit2 target enable, bit3 buffer select (a stored bit) |
| 1 | status | bit0 address hit, bit1 byte received, bit2 byte sent, bit3 transmit empty, bit4 stop seen, bit5 target transmitting, bit6 broadcast hit |
| 2 | interrupt enable | same bit layout as status |
| 3 | own address | 7 bits |
| 4 | data | bytes received from the bus and bytes to send |

`scl_oe` and `sda_oe` pull the open-drain lines low when they are 1. The inputs are synchronised and edge-detected, and the edges drive a state machine with these states:

| State | Meaning |
|---|---|
| IDLE | waiting for a start |
| ADDR | shifting in the address byte |
| HOLD_A | stretching until the address flag is cleared |
| ACK | driving the acknowledge bit, ACK or NACK |
| RX | shifting in a data byte |
| HOLD_R | stretching until the received byte is taken |
| TX | shifting out a data byte |
| TX_ACK | reading the controller's acknowledge |
| HOLD_T | stretching until a new byte is written |
| WAIT | ignoring the bus until a stop or start |

Transitions:
- From any state, a start goes to ADDR and a stop goes to IDLE.
- ADDR goes to HOLD_A on the eighth falling edge if the address hits, and to WAIT if it misses.
- HOLD_A goes to ACK once the flag is cleared.
- ACK goes to RX, TX or WAIT (after a NACK) on the next falling edge.
- RX goes to HOLD_R, and HOLD_R goes to ACK.
- TX goes to TX_ACK.
- TX_ACK goes to HOLD_T if the controller acknowledged, and to WAIT if it did not.
- HOLD_T goes to TX.

Top module: `i2c_tgt`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither line is pulled low.
- R2: When the target is enabled (control bit2) and the address byte's upper 7 bits equal the own address, status bit0 is set and SCL is held low after the eighth bit until bit0 is cleared, after which the target ACKs; a different address, or a disabled target, gets no ACK and sets no flag.
- R3: Status bit5 takes the R/W bit (1 = read) of each matched address byte and is not changed by writes to the status register.
- R4: In write direction each received byte is placed in the data register and sets status bit1, SCL is held low until the data register is read (which clears bit1), then the byte is ACKed.
- R5: If control bit0 is set when a received byte is released, that byte is NACKed, bit0 clears itself, and later bytes are ignored (no stretch, no flag, no ACK) until the next start.
- R6: In read direction the data register's content when the address flag is cleared is sent MSB first. Each byte sent sets status bit2. A controller ACK sets status bit3 and holds SCL low until the data register is written, and that new value is sent next.
- R7: After a controller NACK in read direction, the target leaves SDA released, does not set status bit3, and waits for a stop or start.
- R8: A stop after this target was addressed sets status bit4. A repeated start returns to address detection without setting bit4. A stop while unaddressed sets nothing.
- R9: Writing the status register clears each flag written as 0 and keeps each flag written as 1.
- R10: `irq` is 1 exactly when some status bit is set whose interrupt-enable bit (offset 2, same layout) is also set.
- R11: With control bit1 set, address byte 0x00 is ACKed and sets status bits 6 and 0; with bit1 clear it is not ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | pull SCL low |
| sda_oe | output | 1 | pull SDA low |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (a read of data clears bit1) |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational |
| irq | output | 1 | interrupt |

## Verification
The hardest situation to reach is the clock stretch after a controller ACK in read direction, and its release. The bench has to complete a whole transmitted byte, drive the acknowledge bit, and then release SCL while leaving the transmit-empty flag set. Only then can it observe that the line stays low and write the next byte. The bench's bus model therefore releases SCL in one step and waits for the line to go high in a separate step. Register accesses are placed between those two steps, and that same split is how the one-shot NACK lands on exactly one byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_HOLD_A, ST_ACK, ST_RX,
        ST_HOLD_R, ST_TX, ST_TX_ACK, ST_HOLD_T, ST_WAIT
    } tgt_state_e;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT = 3'd1;
    localparam logic [REG_AW-1:0] A_IEN  = 3'd2;
    localparam logic [REG_AW-1:0] A_OWN  = 3'd3;
    localparam logic [REG_AW-1:0] A_DATA = 3'd4;

    localparam int C_FNACK = 0;
    localparam int C_GCEN  = 1;
    localparam int C_EN    = 2;
    localparam int C_BSEL  = 3;

    localparam int F_ADDR = 0;
    localparam int F_RXD  = 1;
    localparam int F_TXD  = 2;
    localparam int F_TXE  = 3;
    localparam int F_STOP = 4;
    localparam int F_XMIT = 5;
    localparam int F_GC   = 6;
    localparam int NFLAGS = 7;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          enable,
    input  logic          gc_en,
    input  logic          force_nack,
    input  logic [DW-2:0] own_addr,
    input  logic          flag_addr,
    input  logic          flag_rxd,
    input  logic          flag_txe,
    input  logic [DW-1:0] tx_data,
    output logic          set_addr,
    output logic          set_gc,
    output logic          set_stop,
    output logic          set_rxd,
    output logic          set_txd,
    output logic          set_txe,
    output logic          nack_used,
    output logic          rw_bit,
    output logic [DW-1:0] rx_byte,
    output logic          scl_oe,
    output logic          sda_oe
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    tgt_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sh_q, tx_q;
    logic nack_q, mack_q, active_q, rel_q;
    logic hit_own, hit_gc, in_hold;

    assign hit_own = enable && (sh_q[DW-1:1] == own_addr);
    assign hit_gc  = enable && gc_en && (sh_q[DW-1:1] == '0);
    assign in_hold = (state_q == ST_HOLD_A) || (state_q == ST_HOLD_R) || (state_q == ST_HOLD_T);
    assign rw_bit  = sh_q[0];
    assign rx_byte = sh_q;

    // next state and flag events
    always_comb begin
        state_d   = state_q;
        set_addr  = 1'b0;
        set_gc    = 1'b0;
        set_stop  = 1'b0;
        set_rxd   = 1'b0;
        set_txd   = 1'b0;
        set_txe   = 1'b0;
        nack_used = 1'b0;
        if (stop_det) begin
            state_d  = ST_IDLE;
            set_stop = active_q;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR:
                    if (scl_fall && cnt_q == LAST) begin
                        if (hit_own || hit_gc) begin
                            state_d  = ST_HOLD_A;
                            set_addr = 1'b1;
                            set_gc   = hit_gc;
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                ST_HOLD_A: if (!flag_addr) state_d = ST_ACK;
                ST_ACK:
                    if (scl_fall) state_d = nack_q ? ST_WAIT : (active_q && rw_q() ? ST_TX : ST_RX);
                ST_RX:
                    if (scl_fall && cnt_q == LAST) begin
                        set_rxd = 1'b1;
                        state_d = ST_HOLD_R;
                    end
                ST_HOLD_R:
                    if (!flag_rxd) begin
                        state_d   = ST_ACK;
                        nack_used = force_nack;
                    end
                ST_TX:
                    if (scl_fall && cnt_q == LAST - 1'b1) begin
                        set_txd = 1'b1;
                        state_d = ST_TX_ACK;
                    end
                ST_TX_ACK:
                    if (scl_fall) begin
                        if (mack_q) begin
                            set_txe = 1'b1;
                            state_d = ST_HOLD_T;
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                ST_HOLD_T: if (!flag_txe) state_d = ST_TX;
                ST_WAIT:   state_d = ST_WAIT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    logic dir_q;
    function automatic logic rw_q();
        return dir_q;
    endfunction

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            nack_q   <= 1'b0;
            mack_q   <= 1'b0;
            active_q <= 1'b0;
            dir_q    <= 1'b0;
            rel_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rel_q   <= in_hold && (state_d != state_q);
            if (start_det) begin
                cnt_q    <= '0;
                active_q <= 1'b0;
            end else if (stop_det) begin
                active_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[DW-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (set_addr) begin
                            active_q <= 1'b1;
                            dir_q    <= sh_q[0];
                            nack_q   <= 1'b0;
                        end
                    end
                    ST_HOLD_R: if (state_d == ST_ACK) nack_q <= force_nack;
                    ST_ACK: if (scl_fall) begin
                        cnt_q <= '0;
                        tx_q  <= tx_data;
                    end
                    ST_TX: if (scl_fall) begin
                        tx_q  <= {tx_q[DW-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                        if (set_txd) mack_q <= 1'b0;
                    end
                    ST_TX_ACK: if (scl_rise) mack_q <= !sda_s;
                    ST_HOLD_T: if (state_d == ST_TX) begin
                        tx_q  <= tx_data;
                        cnt_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // line drivers
    always_comb begin
        scl_oe = in_hold || rel_q;
        sda_oe = ((state_q == ST_ACK) && !nack_q) || ((state_q == ST_TX) && !tx_q[DW-1]);
    end

    // R6: SDA is only pulled low while SCL is low
    p_sda_change_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic set_addr, set_gc, set_stop, set_rxd, set_txd, set_txe, nack_used, rw_bit;
    logic [DW-1:0] rx_byte, data_q;
    logic [3:0] ctrl_q;
    logic [NFLAGS-1:0] stat_q, stat_d, ien_q;
    logic [DW-2:0] own_q;
    logic wr_stat, wr_ctrl;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .enable(ctrl_q[C_EN]), .gc_en(ctrl_q[C_GCEN]), .force_nack(ctrl_q[C_FNACK]),
        .own_addr(own_q), .flag_addr(stat_q[F_ADDR]), .flag_rxd(stat_q[F_RXD]),
        .flag_txe(stat_q[F_TXE]), .tx_data(data_q),
        .set_addr(set_addr), .set_gc(set_gc), .set_stop(set_stop), .set_rxd(set_rxd),
        .set_txd(set_txd), .set_txe(set_txe), .nack_used(nack_used), .rw_bit(rw_bit),
        .rx_byte(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

    always_comb begin
        stat_d = stat_q;
        if (wr_stat) begin
            stat_d = stat_q & reg_wdata[NFLAGS-1:0];
            stat_d[F_XMIT] = stat_q[F_XMIT];
        end
        if (reg_rd && reg_addr == A_DATA) stat_d[F_RXD] = 1'b0;
        if (reg_wr && reg_addr == A_DATA) stat_d[F_TXE] = 1'b0;
        if (set_addr) begin
            stat_d[F_ADDR] = 1'b1;
            stat_d[F_XMIT] = rw_bit;
        end
        if (set_gc)   stat_d[F_GC]   = 1'b1;
        if (set_stop) stat_d[F_STOP] = 1'b1;
        if (set_rxd)  stat_d[F_RXD]  = 1'b1;
        if (set_txd)  stat_d[F_TXD]  = 1'b1;
        if (set_txe)  stat_d[F_TXE]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            own_q  <= '0;
            data_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_ctrl) ctrl_q <= reg_wdata[3:0];
            else if (nack_used) ctrl_q[C_FNACK] <= 1'b0;
            if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[NFLAGS-1:0];
            if (reg_wr && reg_addr == A_OWN) own_q <= reg_wdata[DW-2:0];
            if (reg_wr && reg_addr == A_DATA) data_q <= reg_wdata;
            else if (set_rxd) data_q <= rx_byte;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[3:0] = ctrl_q;
            A_STAT:  reg_rdata[NFLAGS-1:0] = stat_q;
            A_IEN:   reg_rdata[NFLAGS-1:0] = ien_q;
            A_OWN:   reg_rdata[DW-2:0] = own_q;
            A_DATA:  reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & ien_q);

    // R2: a stretch only begins while a service flag is pending
    p_stretch_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> (stat_q[F_ADDR] | stat_q[F_RXD] | stat_q[F_TXE]));
    // R9: writing all ones to status clears nothing
    p_ones_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[NFLAGS-1:0] == '1) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R3: direction bit is untouched by status writes
    p_dir_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !set_addr) |=> (stat_q[F_XMIT] == $past(stat_q[F_XMIT])));
    // R5: the one-shot NACK bit clears once used
    p_nack_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_used && !wr_ctrl) |=> !ctrl_q[C_FNACK]);
endmodule

// File: tb/i2c_tgt_bench.sv
module i2c_tgt_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line, scl_oe, sda_oe;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq;
    int n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_tgt u_i2c_tgt (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        clks(Q);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; clks(Q);
        scl_up();
        m_sda_low = 1'b1; clks(Q);
        m_scl_low = 1'b1; clks(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; clks(Q);
        scl_up();
        m_sda_low = 1'b0; clks(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = !b; clks(Q);
        scl_up();
        m_scl_low = 1'b1; clks(Q);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // releases SDA and SCL for a controller-read bit; SCL may stay low
    task automatic rel_bit();
        m_sda_low = 1'b0; clks(Q);
        m_scl_low = 1'b0; clks(12);
    endtask

    task automatic finish_bit(output logic b);
        while (!scl_line) @(negedge clk);
        clks(Q);
        b = sda_line;
        m_scl_low = 1'b1; clks(Q);
    endtask

    task automatic recv_bit(output logic b);
        rel_bit();
        finish_bit(b);
    endtask

    task automatic t_reset();
        chk("R1 scl released", scl_line, 1);
        chk("R1 sda released", sda_line, 1);
        chk("R1 irq", irq, 0);
        for (int a = 0; a < 5; a++) rd_chk("R1 register", 3'(a), 8'h00);
    endtask

    task automatic t_mismatch();
        logic b;
        m_start(); send_byte(8'h66); recv_bit(b);
        chk("R2 foreign address NACK", b, 1);
        rd_chk("R2 no flag on miss", 3'd1, 8'h00);
        m_stop(); clks(8);
        rd_chk("R8 no stop flag when unaddressed", 3'd1, 8'h00);
        wr(3'd0, 8'h00);
        m_start(); send_byte(8'h54); recv_bit(b);
        chk("R2 disabled target NACK", b, 1);
        m_stop(); clks(8);
        rd_chk("R2 disabled no flag", 3'd1, 8'h00);
        wr(3'd0, 8'h04);
    endtask

    task automatic t_write();
        logic b;
        wr(3'd2, 8'h13);
        m_start(); send_byte(8'h54); rel_bit();
        chk("R2 stretch after address", scl_line, 0);
        rd_chk("R2 R3 address hit write", 3'd1, 8'h01);
        chk("R10 irq on address", irq, 1);
        wr(3'd1, 8'h7F);
        rd_chk("R9 ones keep flags", 3'd1, 8'h01);
        chk("R2 still stretched", scl_line, 0);
        wr(3'd1, 8'h7E);
        finish_bit(b);
        chk("R2 address ACK", b, 0);
        chk("R10 irq cleared", irq, 0);
        send_byte(8'hA5); rel_bit();
        chk("R4 stretch after byte", scl_line, 0);
        rd_chk("R4 byte received flag", 3'd1, 8'h02);
        rd_chk("R4 received data", 3'd4, 8'hA5);
        finish_bit(b);
        chk("R4 byte ACK", b, 0);
        send_byte(8'h3C); rel_bit();
        wr(3'd0, 8'h05);
        rd_chk("R4 second byte", 3'd4, 8'h3C);
        finish_bit(b);
        chk("R5 forced NACK", b, 1);
        rd_chk("R5 one-shot cleared", 3'd0, 8'h04);
        send_byte(8'h77); rel_bit();
        chk("R5 no stretch after NACK", scl_line, 1);
        finish_bit(b);
        chk("R5 later byte not ACKed", b, 1);
        rd_chk("R5 no flag after NACK", 3'd1, 8'h00);
        m_stop(); clks(8);
        rd_chk("R8 stop flag", 3'd1, 8'h10);
        chk("R10 irq on stop", irq, 1);
        wr(3'd1, 8'h6F);
        chk("R9 zero clears", irq, 0);
    endtask

    task automatic t_read();
        logic b;
        logic [7:0] v;
        wr(3'd2, 8'h08);
        m_start(); send_byte(8'h55); rel_bit();
        chk("R2 stretch read address", scl_line, 0);
        rd_chk("R3 read direction", 3'd1, 8'h21);
        chk("R10 irq masked", irq, 0);
        wr(3'd4, 8'h96);
        wr(3'd1, 8'h00);
        rd_chk("R3 direction kept on write", 3'd1, 8'h20);
        finish_bit(b);
        chk("R2 read address ACK", b, 0);
        v = '0;
        for (int i = 0; i < 8; i++) begin recv_bit(b); v = {v[6:0], b}; end
        chk("R6 first byte", v, 8'h96);
        rd_chk("R6 byte sent flag", 3'd1, 8'h24);
        send_bit(1'b0); clks(4);
        rd_chk("R6 transmit empty flag", 3'd1, 8'h2C);
        chk("R10 irq on empty", irq, 1);
        rel_bit();
        chk("R6 stretch until refill", scl_line, 0);
        wr(3'd4, 8'h5B);
        finish_bit(b); v = {7'd0, b};
        for (int i = 0; i < 7; i++) begin recv_bit(b); v = {v[6:0], b}; end
        chk("R6 second byte", v, 8'h5B);
        send_bit(1'b1); clks(12);
        chk("R7 SDA released", sda_line, 1);
        rd_chk("R7 no empty flag after NACK", 3'd1, 8'h24);
        wr(3'd1, 8'h00);
        m_sda_low = 1'b0; clks(Q); scl_up();
        m_sda_low = 1'b1; clks(Q); m_scl_low = 1'b1; clks(Q);
        send_byte(8'h54); rel_bit();
        rd_chk("R8 R3 repeated start write", 3'd1, 8'h01);
        wr(3'd1, 8'h7E);
        finish_bit(b);
        chk("R8 ACK after repeated start", b, 0);
        m_stop(); clks(8);
        rd_chk("R8 stop after restart", 3'd1, 8'h10);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_general();
        logic b;
        wr(3'd0, 8'h06);
        m_start(); send_byte(8'h00); rel_bit();
        rd_chk("R11 broadcast flags", 3'd1, 8'h41);
        wr(3'd1, 8'h00);
        finish_bit(b);
        chk("R11 broadcast ACK", b, 0);
        m_stop(); clks(8);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h04);
        m_start(); send_byte(8'h00); recv_bit(b);
        chk("R11 broadcast disabled NACK", b, 1);
        m_stop(); clks(8);
        rd_chk("R11 no flags", 3'd1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(5);
        t_reset();
        wr(3'd3, 8'h2A);
        wr(3'd0, 8'h04);
        t_mismatch();
        t_write();
        t_read();
        t_general();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule